// File: doc/BRIEF.md
# Hysteretic Video Lock Status Filter

This block turns per-line lock indications from a video front end into one debounced lock flag. On each video line a strobe arrives together with an instantaneous horizontal-sync lock bit and a colour-subcarrier lock bit. From these the block forms a raw line condition. A selectable option decides whether subcarrier lock must also hold, or whether horizontal lock alone is enough.

The reported flag changes only after the raw condition has disagreed with it on a run of consecutive lines. Entering lock and leaving lock each have a run length of their own. Each length comes from a 3-bit code that selects one of eight log-spaced line counts. The recommended reset value for both codes is `100`, which gives 100 lines. The instantaneous horizontal lock is also passed straight through on its own output. A receiver in component mode needs that bit, and in that mode the subcarrier option must stay off.

Top module: `vlock_filter`

## Requirements
- R1: While `rst` is high and on the first clock after it, `lock_out` is 0 and the run of disagreeing lines is empty.
- R2: With `fsc_lock_en` = 0 the raw line condition equals `hlock_in`, and `fsc_lock_in` has no effect on `lock_out`.
- R3: With `fsc_lock_en` = 1 the raw line condition is `hlock_in` AND `fsc_lock_in`. A line with subcarrier lock low counts as not locked.
- R4: While unlocked, `lock_out` rises on the clock edge that samples the N-th consecutive strobed line with a true raw condition, where N comes from `enter_code`.
- R5: While locked, `lock_out` falls on the clock edge that samples the N-th consecutive strobed line with a false raw condition, where N comes from `leave_code`.
- R6: Both codes map to line counts as follows: 0→1, 1→2, 2→5, 3→10, 4→100, 5→500, 6→1000, 7→100000.
- R7: A strobed line whose raw condition matches the current `lock_out` empties the run, so an interrupted run starts again from zero.
- R8: Clock edges without `line_stb` neither change `lock_out` nor extend the run, whatever the lock inputs do.
- R9: `hlock_raw_out` follows `hlock_in` combinationally, whatever the option setting and the filter state.
- R10: A new code value is used from the next strobed line onward. The run already collected is kept, so a shorter count can end a run that has already started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_stb | input | 1 | One-cycle pulse per video line, qualifies the lock inputs |
| hlock_in | input | 1 | Instantaneous horizontal-sync lock |
| fsc_lock_in | input | 1 | Instantaneous colour-subcarrier lock |
| fsc_lock_en | input | 1 | 1: subcarrier lock joins the raw condition |
| enter_code | input | 3 | Line-count code for entering lock |
| leave_code | input | 3 | Line-count code for leaving lock |
| lock_out | output | 1 | Filtered lock flag, 1 = locked |
| hlock_raw_out | output | 1 | Pass-through of `hlock_in` |

## Verification
The filtered flag holds one register stage. A strobed line sampled on a rising edge shows its effect on `lock_out` right after that same edge. The bench drives each line on a falling edge and compares on the next falling edge, so every line is checked one half cycle after the edge that consumed it. The driver queues one expected flag value per line. The monitor pops that value exactly when a strobe has been seen at a rising edge, so every line gets exactly one comparison. `hlock_raw_out` has no register stage, so it is compared in the same half cycle in which `hlock_in` is changed.

// File: rtl/vlock_pkg.sv
package vlock_pkg;

    localparam int CNT_W = 17;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        LC_1    = 3'd0,
        LC_2    = 3'd1,
        LC_5    = 3'd2,
        LC_10   = 3'd3,
        LC_100  = 3'd4,
        LC_500  = 3'd5,
        LC_1000 = 3'd6,
        LC_100K = 3'd7
    } line_code_e;

    localparam line_code_e CODE_DEFAULT = LC_100;

    typedef enum logic {
        ST_UNLOCKED = 1'b0,
        ST_LOCKED   = 1'b1
    } lock_state_e;

    typedef struct packed {
        logic stb;
        logic hlock;
        logic fsc;
    } line_sample_t;

    function automatic cnt_t code_to_lines(input line_code_e code);
        cnt_t n;
        case (code)
            LC_1:    n = cnt_t'(1);
            LC_2:    n = cnt_t'(2);
            LC_5:    n = cnt_t'(5);
            LC_10:   n = cnt_t'(10);
            LC_100:  n = cnt_t'(100);
            LC_500:  n = cnt_t'(500);
            LC_1000: n = cnt_t'(1000);
            default: n = cnt_t'(100000);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/vlock_cond.sv
module vlock_cond
    import vlock_pkg::*;
(
    input  line_sample_t smp,
    input  logic         fsc_en,
    output logic         raw_ok
);
    always_comb begin
        if (fsc_en) raw_ok = smp.hlock & smp.fsc;
        else        raw_ok = smp.hlock;
    end
endmodule

// File: rtl/vlock_thresh.sv
module vlock_thresh
    import vlock_pkg::*;
(
    input  lock_state_e state,
    input  logic [2:0]  enter_code,
    input  logic [2:0]  leave_code,
    output cnt_t        limit
);
    line_code_e sel;
    always_comb begin
        sel   = (state == ST_LOCKED) ? line_code_e'(leave_code) : line_code_e'(enter_code);
        limit = code_to_lines(sel);
    end
endmodule

// File: rtl/vlock_run.sv
module vlock_run
    import vlock_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic disagree,
    input  cnt_t limit,
    output logic flip,
    output cnt_t count
);
    cnt_t count_q;
    cnt_t next_len;

    always_comb begin
        next_len = count_q + cnt_t'(1);
        flip     = stb & disagree & (next_len >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst)                 count_q <= '0;
        else if (stb) begin
            if (!disagree || flip) count_q <= '0;
            else                   count_q <= next_len;
        end
    end

    assign count = count_q;

    p_run_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        !stb |=> $stable(count_q));
endmodule

// File: rtl/vlock_filter.sv
module vlock_filter
    import vlock_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       line_stb,
    input  logic       hlock_in,
    input  logic       fsc_lock_in,
    input  logic       fsc_lock_en,
    input  logic [2:0] enter_code,
    input  logic [2:0] leave_code,
    output logic       lock_out,
    output logic       hlock_raw_out
);
    line_sample_t smp;
    lock_state_e  state_q;
    logic         raw_ok;
    logic         flip;
    cnt_t         limit;
    cnt_t         run_len;

    assign smp = '{stb: line_stb, hlock: hlock_in, fsc: fsc_lock_in};

    vlock_cond u_cond (
        .smp    (smp),
        .fsc_en (fsc_lock_en),
        .raw_ok (raw_ok)
    );

    vlock_thresh u_thresh (
        .state      (state_q),
        .enter_code (enter_code),
        .leave_code (leave_code),
        .limit      (limit)
    );

    vlock_run u_run (
        .clk      (clk),
        .rst      (rst),
        .stb      (line_stb),
        .disagree (raw_ok != state_q),
        .limit    (limit),
        .flip     (flip),
        .count    (run_len)
    );

    always_ff @(posedge clk) begin
        if (rst)       state_q <= ST_UNLOCKED;
        else if (flip) state_q <= (state_q == ST_LOCKED) ? ST_UNLOCKED : ST_LOCKED;
    end

    assign lock_out      = state_q;
    assign hlock_raw_out = hlock_in;

    p_reset_unlocked_r1: assert property (@(posedge clk)
        rst |=> (!lock_out && run_len == '0));

    p_hold_no_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        !line_stb |=> $stable(lock_out));

    p_rise_needs_raw_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_out) |-> ($past(line_stb) && $past(raw_ok)));

    p_fall_needs_loss_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_out) |-> ($past(line_stb) && !$past(raw_ok)));

    p_agree_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (line_stb && (raw_ok == lock_out)) |=> (run_len == '0));

    p_fsc_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (line_stb && !fsc_lock_en && hlock_in && !lock_out && enter_code == 3'd0) |=> lock_out);

    p_fsc_blocks_r3: assert property (@(posedge clk) disable iff (rst)
        (line_stb && fsc_lock_en && !fsc_lock_in) |=> !$rose(lock_out));
endmodule

// File: tb/vlock_filter_bench.sv
module vlock_filter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_stb = 1'b0;
    logic       hlock_in = 1'b0;
    logic       fsc_lock_in = 1'b0;
    logic       fsc_lock_en = 1'b0;
    logic [2:0] enter_code = 3'd4;
    logic [2:0] leave_code = 3'd4;
    logic       lock_out;
    logic       hlock_raw_out;

    int checks = 0;
    int errors = 0;
    item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    vlock_filter u_vlock_filter (
        .clk(clk), .rst(rst), .line_stb(line_stb), .hlock_in(hlock_in),
        .fsc_lock_in(fsc_lock_in), .fsc_lock_en(fsc_lock_en),
        .enter_code(enter_code), .leave_code(leave_code),
        .lock_out(lock_out), .hlock_raw_out(hlock_raw_out)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic line(input logic h, input logic f, input logic exp, input string tag);
        item_t it;
        @(negedge clk);
        hlock_in = h; fsc_lock_in = f; line_stb = 1'b1;
        it.exp = exp; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        line_stb = 1'b0;
    endtask

    task automatic lines(input int n, input logic h, input logic f,
                         input logic e_mid, input logic e_last, input string tag);
        for (int i = 0; i < n; i++)
            line(h, f, (i == n-1) ? e_last : e_mid, tag);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            if (line_stb) begin
                @(negedge clk);
                if (sb.size() == 0) begin
                    check(1'b1, 1'b0, "scoreboard empty");
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check(lock_out, it.exp, it.tag);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        check(lock_out, 1'b0, "R1 reset state");
        rst = 1'b0;
        @(negedge clk);
        check(lock_out, 1'b0, "R1 after reset");

        // R9 pass-through
        hlock_in = 1'b1; #1; check(hlock_raw_out, 1'b1, "R9 raw high");
        hlock_in = 1'b0; #1; check(hlock_raw_out, 1'b0, "R9 raw low");

        // R4/R5/R6 with shortest counts
        enter_code = 3'd0; leave_code = 3'd0;
        line(1, 0, 1, "R4 code0 enter");
        line(0, 0, 0, "R5 code0 leave");

        // R6 codes 1 and 2
        enter_code = 3'd1;
        lines(2, 1, 0, 0, 1, "R6 code1 enter");
        leave_code = 3'd2;
        lines(5, 0, 0, 1, 0, "R6 code2 leave");

        // R7 interrupted run
        enter_code = 3'd3;
        lines(9, 1, 0, 0, 0, "R7 partial run");
        line(0, 0, 0, "R7 agreeing line");
        lines(10, 1, 0, 0, 1, "R7 restarted run");

        // R2 subcarrier ignored when option off
        leave_code = 3'd0; enter_code = 3'd0; fsc_lock_en = 1'b0;
        line(0, 1, 0, "R2 fsc high hlock low");
        line(1, 0, 1, "R2 fsc low hlock high");

        // R3 subcarrier joins condition
        fsc_lock_en = 1'b1;
        line(1, 0, 0, "R3 fsc low unlocks");
        line(1, 1, 1, "R3 both high locks");
        line(0, 1, 0, "R3 hlock low unlocks");
        fsc_lock_en = 1'b0;

        // R8 no strobe, no effect
        enter_code = 3'd1;
        hlock_in = 1'b1;
        repeat (20) @(negedge clk);
        check(lock_out, 1'b0, "R8 idle cycles");
        line(1, 0, 0, "R8 run not extended");
        line(1, 0, 1, "R8 second line locks");

        // R6 long counts
        leave_code = 3'd4;
        lines(100, 0, 0, 1, 0, "R6 code4 leave");
        enter_code = 3'd4;
        lines(100, 1, 0, 0, 1, "R6 code4 enter");
        leave_code = 3'd5;
        lines(500, 0, 0, 1, 0, "R6 code5 leave");
        enter_code = 3'd6;
        lines(1000, 1, 0, 0, 1, "R6 code6 enter");

        // R10 code change keeps run
        leave_code = 3'd4;
        lines(3, 0, 0, 1, 1, "R10 run before change");
        leave_code = 3'd0;
        line(0, 0, 0, "R10 shorter leave code");
        enter_code = 3'd5;
        lines(4, 1, 0, 0, 0, "R10 run before change");
        enter_code = 3'd2;
        line(1, 0, 1, "R10 fifth line locks");

        @(negedge clk);
        @(negedge clk);
        check(sb.size() == 0, 1'b1, "R4 scoreboard drained");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule